// File: doc/BRIEF.md
# Triggered DAC Sample Conditioning Channel

This block prepares the output code for a single digital-to-analog converter channel. A new 12-bit code is produced only when a trigger is accepted. The trigger comes from one of three sources, chosen by a mode input. The first is a tick from a programmable integer divider of the system clock. The second is a rising edge on one of eight external trigger lines. The third is a one-cycle software strobe.

On each accepted trigger the present input sample is read and conditioned. It is read as either unsigned or two's-complement data. It is scaled by a power of two in either direction, an unsigned offset is added, the result is optionally negated, and it is then clamped to the 12-bit range of the active number format. The result is registered together with a one-cycle valid strobe. A run flag shows whether the channel is enabled.

All configuration arrives on plain input ports. The bus interface, the analog converter and any waveform source stay outside the block and connect to these ports.

Top module: `dacc_channel`

## Requirements
- R1: `trig_mode` selects the trigger source: 0 is the internal divider, 1 is the external line chosen by `ext_sel`, 2 is `sw_trig`, and 3 accepts no trigger at all. Sources that are not selected have no effect on the outputs.
- R2: In mode 0 with `div_value` = N, the divider counts from 0 up to N and fires once per N+1 clocks. After a switch into mode 0, the first accepted trigger is the N+1th clock edge. N = 0 fires on every clock.
- R3: In mode 1, a rising edge on `ext_trig[ext_sel]` passes through two synchronizer flops and is accepted once. `code_valid` is high after the third clock edge that follows the line going high. A line held high gives no further triggers, and a line that is not selected gives none.
- R4: In mode 2, each clock cycle with `sw_trig` high is one accepted trigger.
- R5: When `scale_up` = 1 the sample is shifted left by `scale` (0..7) places. When `scale_up` = 0 it is shifted right by `scale` places. Right shifts of signed data are arithmetic, so they round toward minus infinity.
- R6: The 8-bit `offset` is added as an unsigned value (0..255) after scaling.
- R7: With `signed_mode` = 0, input and output codes are unsigned in the range 0..4095. With `signed_mode` = 1, they are two's complement in the range -2048..2047.
- R8: With `negate` = 1, the sign of the sum is flipped after the offset add and before the clamp.
- R9: Results outside the range of the active format saturate to that range's minimum or maximum and never wrap.
- R10: `code_out` and `code_valid` are loaded on the clock edge that accepts a trigger. `code_valid` is a one-cycle pulse, and `code_out` holds its value until the next accepted trigger.
- R11: With `enable` low, no trigger is accepted and the divider stays at zero. `running` equals `enable` delayed by one clock.
- R12: After reset, `code_out` is 0 and both `code_valid` and `running` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Channel enable |
| trig_mode | input | 2 | Trigger source select (0 divider, 1 external, 2 software, 3 none) |
| ext_sel | input | 3 | Index of the external trigger line |
| ext_trig | input | 8 | Asynchronous external trigger lines |
| sw_trig | input | 1 | Software trigger strobe, one cycle per trigger |
| div_value | input | 19 | Divider terminal count |
| scale | input | 3 | Shift distance, 0 to 7 |
| scale_up | input | 1 | 1 shifts left (multiply), 0 shifts right (divide) |
| offset | input | 8 | Unsigned offset added after scaling |
| signed_mode | input | 1 | 1 treats data as two's complement |
| negate | input | 1 | Flip the sign before clamping |
| sample_in | input | 12 | Input sample |
| code_out | output | 12 | Registered conditioned output code |
| code_valid | output | 1 | One-cycle strobe when code_out is loaded |
| running | output | 1 | Channel operating flag |

## Verification
The bench checks the arithmetic with cases where the order of operations shows in the result. A design that added the offset before scaling, or negated before the offset, returns a visibly different code. It also drives values just past each clamp limit in both formats, where a wrapping design would return a code at the opposite end of the range. The case of a negative signed sample shifted right would expose a logical shift, which gives a large positive number. Timing checks count the divider period and the external-edge latency, which would expose an off-by-one count or a missing synchronizer stage. They also confirm that a held external level or a disabled channel produces no extra valid strobe.

// File: rtl/dacc_pkg.sv
// Shared types for the DAC conditioning channel.
// Assumes: trigger mode is a 2-bit code, with value 3 reserved for "no trigger".
package dacc_pkg;
    typedef enum logic [1:0] {
        TRG_INTERNAL = 2'd0,
        TRG_EXTERNAL = 2'd1,
        TRG_SOFTWARE = 2'd2,
        TRG_NONE     = 2'd3
    } trig_mode_e;
endpackage

// File: rtl/dacc_tick_divider.sv
// Integer clock divider: counts 0..div_value and raises tick while at the limit.
// Assumes: run low holds the count at zero. If div_value drops below the current
// count, the tick fires at once and the count restarts.
module dacc_tick_divider #(
    parameter int DIV_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_value,
    output logic             tick
);
    logic [DIV_W-1:0] count_q;
    logic             at_limit;

    // Detect the terminal count.
    assign at_limit = (count_q >= div_value);
    assign tick     = run && at_limit;

    // Advance or restart the count.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            count_q <= '0;
        end else if (at_limit) begin
            count_q <= '0;
        end else begin
            count_q <= count_q + 1'b1;
        end
    end
endmodule

// File: rtl/dacc_trig_select.sv
// Trigger selection: synchronizes the external lines, detects rising edges and
// picks one source by mode.
// Assumes: the external lines are asynchronous, sw_trig is synchronous, and
// div_tick comes from dacc_tick_divider.
module dacc_trig_select
    import dacc_pkg::*;
#(
    parameter int N_EXT       = 8,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W      = $clog2(N_EXT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [1:0]       mode,
    input  logic [SEL_W-1:0] ext_sel,
    input  logic [N_EXT-1:0] ext_trig,
    input  logic             sw_trig,
    input  logic             div_tick,
    output logic             fire
);
    // Stage SYNC_STAGES is the previous-value flop used for edge detection.
    logic [N_EXT-1:0] chain_q [SYNC_STAGES+1];
    logic [N_EXT-1:0] rise;

    // First synchronizer flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= '0;
        else        chain_q[0] <= ext_trig;
    end

    for (genvar s = 1; s <= SYNC_STAGES; s++) begin : g_sync
        // Later synchronizer stages and the history flop.
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= chain_q[s-1];
        end
    end

    assign rise = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

    // Route the source chosen by mode.
    always_comb begin
        unique case (trig_mode_e'(mode))
            TRG_INTERNAL: fire = div_tick;
            TRG_EXTERNAL: fire = rise[ext_sel];
            TRG_SOFTWARE: fire = sw_trig;
            default:      fire = 1'b0;
        endcase
        fire = fire && enable;
    end
endmodule

// File: rtl/dacc_conditioner.sv
// Combinational sample path: interpret the sign, shift by a power of two, add
// the offset, optionally negate, then clamp to the output format.
// Assumes: the working width holds the largest left shift plus the offset
// without overflow.
module dacc_conditioner #(
    parameter int SMP_W   = 12,
    parameter int SCALE_W = 3,
    parameter int OFF_W   = 8,
    localparam int WORK_W = SMP_W + (1 << SCALE_W) + 2
) (
    input  logic [SMP_W-1:0]   sample,
    input  logic [SCALE_W-1:0] scale,
    input  logic               scale_up,
    input  logic [OFF_W-1:0]   offset,
    input  logic               signed_mode,
    input  logic               negate,
    output logic [SMP_W-1:0]   code
);
    localparam logic signed [WORK_W-1:0] U_MAX = WORK_W'((1 << SMP_W) - 1);
    localparam logic signed [WORK_W-1:0] U_MIN = '0;
    localparam logic signed [WORK_W-1:0] S_MAX = WORK_W'((1 << (SMP_W - 1)) - 1);
    localparam logic signed [WORK_W-1:0] S_MIN = WORK_W'(-(1 << (SMP_W - 1)));

    logic signed [WORK_W-1:0] widened, shifted, summed, flipped, hi, lo, clamped;

    // Scale, offset, negate and clamp in that order.
    always_comb begin
        widened = signed_mode ? {{(WORK_W-SMP_W){sample[SMP_W-1]}}, sample}
                              : {{(WORK_W-SMP_W){1'b0}}, sample};
        shifted = scale_up ? (widened <<< scale) : (widened >>> scale);
        summed  = shifted + $signed({{(WORK_W-OFF_W){1'b0}}, offset});
        flipped = negate ? -summed : summed;
        hi      = signed_mode ? S_MAX : U_MAX;
        lo      = signed_mode ? S_MIN : U_MIN;
        if (flipped > hi)      clamped = hi;
        else if (flipped < lo) clamped = lo;
        else                   clamped = flipped;
        code = clamped[SMP_W-1:0];
    end
endmodule

// File: rtl/dacc_channel.sv
// Top of the triggered DAC conditioning channel. Joins the divider, the trigger
// selector and the conditioner, and registers the output code on each trigger.
// Assumes: all configuration inputs are synchronous to clk. Reset is synchronous
// and active low.
module dacc_channel
    import dacc_pkg::*;
#(
    parameter int SMP_W   = 12,
    parameter int SCALE_W = 3,
    parameter int OFF_W   = 8,
    parameter int DIV_W   = 19,
    parameter int N_EXT   = 8,
    localparam int SEL_W  = $clog2(N_EXT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [1:0]         trig_mode,
    input  logic [SEL_W-1:0]   ext_sel,
    input  logic [N_EXT-1:0]   ext_trig,
    input  logic               sw_trig,
    input  logic [DIV_W-1:0]   div_value,
    input  logic [SCALE_W-1:0] scale,
    input  logic               scale_up,
    input  logic [OFF_W-1:0]   offset,
    input  logic               signed_mode,
    input  logic               negate,
    input  logic [SMP_W-1:0]   sample_in,
    output logic [SMP_W-1:0]   code_out,
    output logic               code_valid,
    output logic               running
);
    logic             div_run, div_tick, fire;
    logic [SMP_W-1:0] cond_code;

    assign div_run = enable && (trig_mode_e'(trig_mode) == TRG_INTERNAL);

    dacc_tick_divider #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(div_run),
        .div_value(div_value), .tick(div_tick)
    );

    dacc_trig_select #(.N_EXT(N_EXT), .SYNC_STAGES(2)) u_sel (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mode(trig_mode),
        .ext_sel(ext_sel), .ext_trig(ext_trig), .sw_trig(sw_trig),
        .div_tick(div_tick), .fire(fire)
    );

    dacc_conditioner #(.SMP_W(SMP_W), .SCALE_W(SCALE_W), .OFF_W(OFF_W)) u_cond (
        .sample(sample_in), .scale(scale), .scale_up(scale_up),
        .offset(offset), .signed_mode(signed_mode), .negate(negate),
        .code(cond_code)
    );

    // Output register: load the code on a trigger, pulse valid, track enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_out   <= '0;
            code_valid <= 1'b0;
            running    <= 1'b0;
        end else begin
            running    <= enable;
            code_valid <= fire;
            if (fire) code_out <= cond_code;
        end
    end
endmodule

// File: rtl/dacc_channel_chk.sv
// Port-level protocol checks for dacc_channel, attached to it by bind.
// Assumes: the default parameter widths.
module dacc_channel_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        enable,
    input logic [1:0]  trig_mode,
    input logic        sw_trig,
    input logic [18:0] div_value,
    input logic [11:0] code_out,
    input logic        code_valid,
    input logic        running
);
    // R1: the reserved mode accepts nothing.
    a_r1_reserved_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_mode == 2'd3) |=> !code_valid);
    // R2: a zero divide value fires on every clock.
    a_r2_div_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && trig_mode == 2'd0 && div_value == 19'd0) |=> code_valid);
    // R4: a software strobe gives a valid code on the next cycle.
    a_r4_sw_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && trig_mode == 2'd2 && sw_trig) |=> code_valid);
    // R10: the code changes only together with a valid strobe.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code_out) |-> code_valid);
    // R11: a disabled channel produces no strobe.
    a_r11_no_valid_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !code_valid);
    // R11: running follows enable one clock later.
    a_r11_run_on: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> running);
    a_r11_run_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !running);
endmodule

bind dacc_channel dacc_channel_chk u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .trig_mode(trig_mode),
    .sw_trig(sw_trig), .div_value(div_value), .code_out(code_out),
    .code_valid(code_valid), .running(running)
);

// File: tb/dacc_channel_tb.sv
// Self-checking bench for dacc_channel: a vector table for the sample path, then
// directed tests for reset, trigger sources, timing and corner cases.
module dacc_channel_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [1:0]  trig_mode = 2'd3;
    logic [2:0]  ext_sel = '0;
    logic [7:0]  ext_trig = '0;
    logic        sw_trig = 1'b0;
    logic [18:0] div_value = '0;
    logic [2:0]  scale = '0;
    logic        scale_up = 1'b0;
    logic [7:0]  offset = '0;
    logic        signed_mode = 1'b0;
    logic        negate = 1'b0;
    logic [11:0] sample_in = '0;
    logic [11:0] code_out;
    logic        code_valid;
    logic        running;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dacc_channel u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .trig_mode(trig_mode),
        .ext_sel(ext_sel), .ext_trig(ext_trig), .sw_trig(sw_trig),
        .div_value(div_value), .scale(scale), .scale_up(scale_up),
        .offset(offset), .signed_mode(signed_mode), .negate(negate),
        .sample_in(sample_in), .code_out(code_out), .code_valid(code_valid),
        .running(running)
    );

    // Entry: sample, scale, up, offset, signed, negate, expected code.
    localparam int NV = 15;
    localparam logic [37:0] VEC [NV] = '{
        {12'h123, 3'd0, 1'b0, 8'h00, 1'b0, 1'b0, 12'h123}, // R7 passthrough
        {12'h100, 3'd2, 1'b1, 8'h00, 1'b0, 1'b0, 12'h400}, // R5 left by 2
        {12'h100, 3'd4, 1'b1, 8'h00, 1'b0, 1'b0, 12'hFFF}, // R9 upper clamp
        {12'hFFF, 3'd7, 1'b0, 8'h00, 1'b0, 1'b0, 12'h01F}, // R5 right by 7
        {12'h010, 3'd0, 1'b0, 8'hFF, 1'b0, 1'b0, 12'h10F}, // R6 offset 255
        {12'hF01, 3'd0, 1'b0, 8'hFF, 1'b0, 1'b0, 12'hFFF}, // R9 offset past top
        {12'h010, 3'd0, 1'b0, 8'h00, 1'b0, 1'b1, 12'h000}, // R8 unsigned negate
        {12'h800, 3'd1, 1'b0, 8'h00, 1'b1, 1'b0, 12'hC00}, // R5 arithmetic shift
        {12'hFFF, 3'd3, 1'b0, 8'h00, 1'b1, 1'b0, 12'hFFF}, // R5 -1 stays -1
        {12'h400, 3'd1, 1'b1, 8'h00, 1'b1, 1'b0, 12'h7FF}, // R9 signed max
        {12'h800, 3'd0, 1'b0, 8'h00, 1'b1, 1'b1, 12'h7FF}, // R8 negate min
        {12'h7F0, 3'd0, 1'b0, 8'h20, 1'b1, 1'b0, 12'h7FF}, // R6 signed offset clamp
        {12'h800, 3'd1, 1'b1, 8'h00, 1'b1, 1'b0, 12'h800}, // R9 signed min
        {12'h005, 3'd0, 1'b0, 8'h10, 1'b1, 1'b1, 12'hFEB}, // R8 offset then negate
        {12'h064, 3'd1, 1'b0, 8'h0A, 1'b0, 1'b0, 12'h03C}  // R6 scale then offset
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic sw_pulse();
        trig_mode = 2'd2;
        sw_trig = 1'b1;
        @(negedge clk);
        sw_trig = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R10 actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int first_idx;
        int nvalid;
        logic [11:0] held;
        repeat (3) @(negedge clk);
        // R12: reset values.
        check(code_out == 12'h000, "R12 code", code_out, 0);
        check(code_valid == 1'b0, "R12 valid", code_valid, 0);
        check(running == 1'b0, "R12 running", running, 0);
        rst_n = 1'b1;
        enable = 1'b1;
        @(negedge clk);
        check(running == 1'b1, "R11 running on", running, 1);

        // Table walk, software trigger (R4, R5..R9).
        for (int i = 0; i < NV; i++) begin
            sample_in   = VEC[i][37:26];
            scale       = VEC[i][25:23];
            scale_up    = VEC[i][22];
            offset      = VEC[i][21:14];
            signed_mode = VEC[i][13];
            negate      = VEC[i][12];
            sw_pulse();
            check(code_valid == 1'b1, "R4 valid", code_valid, 1);
            check(code_out == VEC[i][11:0], "R5-9 vector code", code_out, VEC[i][11:0]);
        end
        // R10: valid is a single pulse, the code holds.
        held = code_out;
        sample_in = 12'h555; signed_mode = 1'b0; negate = 1'b0; offset = 8'h00;
        scale = 3'd0;
        repeat (3) begin
            @(negedge clk);
            check(code_valid == 1'b0, "R10 pulse", code_valid, 0);
            check(code_out == held, "R10 hold", code_out, held);
        end

        // R1: the reserved mode ignores sw_trig and a selected external edge.
        trig_mode = 2'd3; ext_sel = 3'd1; sw_trig = 1'b1; ext_trig[1] = 1'b1;
        nvalid = 0;
        repeat (6) begin @(negedge clk); if (code_valid) nvalid++; end
        sw_trig = 1'b0; ext_trig = '0;
        check(nvalid == 0, "R1 reserved mode", nvalid, 0);
        check(code_out == held, "R1 code untouched", code_out, held);

        // R2: divide value 3 gives first trigger on the 4th edge, period 4.
        div_value = 19'd3;
        trig_mode = 2'd0;
        first_idx = -1; nvalid = 0;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            if (code_valid) begin
                nvalid++;
                if (first_idx < 0) first_idx = k;
            end
        end
        check(first_idx == 4, "R2 first tick", first_idx, 4);
        check(nvalid == 5, "R2 tick count", nvalid, 5);
        check(code_out == 12'h555, "R2 code", code_out, 12'h555);
        // R2: divide value 0 fires every cycle.
        div_value = 19'd0;
        trig_mode = 2'd3;
        @(negedge clk);
        trig_mode = 2'd0;
        nvalid = 0;
        repeat (5) begin @(negedge clk); if (code_valid) nvalid++; end
        check(nvalid == 5, "R2 zero divide", nvalid, 5);
        trig_mode = 2'd3;
        repeat (4) @(negedge clk);

        // R3: selected line edge, valid on 3rd edge, once for a held level.
        trig_mode = 2'd1; ext_sel = 3'd5; sample_in = 12'h2AA;
        ext_trig[5] = 1'b1;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            check(code_valid == (k == 3), "R3 edge latency", code_valid, (k == 3));
        end
        check(code_out == 12'h2AA, "R3 code", code_out, 12'h2AA);
        ext_trig[5] = 1'b0;
        repeat (4) @(negedge clk);
        // R3: an unselected line does nothing.
        ext_trig[2] = 1'b1;
        nvalid = 0;
        repeat (6) begin @(negedge clk); if (code_valid) nvalid++; end
        check(nvalid == 0, "R3 unselected line", nvalid, 0);
        ext_trig = '0;
        // R1: mode 1 ignores the software strobe.
        sw_trig = 1'b1;
        trig_mode = 2'd1;
        @(negedge clk);
        sw_trig = 1'b0;
        @(negedge clk);
        check(code_valid == 1'b0, "R1 sw in external mode", code_valid, 0);

        // R11: disabled channel ignores triggers and clears running.
        enable = 1'b0; trig_mode = 2'd3;
        @(negedge clk);
        check(running == 1'b0, "R11 running off", running, 0);
        held = code_out;
        sample_in = 12'h0F0;
        sw_pulse();
        check(code_valid == 1'b0, "R11 sw disabled", code_valid, 0);
        trig_mode = 2'd0; div_value = 19'd0;
        repeat (3) @(negedge clk);
        check(code_valid == 1'b0, "R11 divider disabled", code_valid, 0);
        check(code_out == held, "R11 code untouched", code_out, held);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule